// File: doc/BRIEF.md
# Compressed Branch Target Unit

This block resolves the control-transfer formats of a 16-bit compressed instruction set. For each instruction presented with a valid strobe it works out five things: whether the branch is taken, the next program counter, whether the link register is written and with what value, whether execution leaves compressed mode, and whether the word is an undefined encoding or a software-interrupt request. The forms it handles are the conditional short branch, the unconditional branch, the two-halfword long branch-with-link and the exchange form of its second half.

The long branch-with-link is split over two instructions. The first half places a partial target in the link register. The second half adds its low offset to that value and jumps to the result. The second half also writes the return address, with bit 0 set, into the link register. No state is kept inside the block between the two halves.

The condition-code check for all fourteen conditions is done inline from the N/Z/C/V flag inputs. All results are registered. They appear in the cycle after the valid strobe, and the flags among them last for exactly one cycle, so the redirect output works as a single-cycle pipeline flush pulse.

Top module: `cbt_unit`

## Requirements
- R1: While reset is held, and after it is released until the first valid instruction, every output strobe is 0 and `nextPc` is 0.
- R2: A conditional branch has `instWord[15:12]` = 4'b1101 and its condition code in `instWord[11:8]`. Each code holds as follows:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C & !Z
  - 9: !C | Z
  - 10: N == V
  - 11: N != V
  - 12: !Z & (N == V)
  - 13: Z | (N != V)
- R3: A conditional branch whose condition holds sets `redirect` and `isBranch`. It gives `nextPc` = PC + 4 + (`instWord[7:0]` sign-extended, times 2).
- R4: A conditional branch whose condition fails sets `isBranch`, leaves `redirect` at 0 and gives `nextPc` = PC + 2.
- R5: In the conditional group, code 4'hF raises `swiTrap` and code 4'hE raises `undefInst`. Neither one redirects or writes the link register, and both give `nextPc` = PC + 2.
- R6: `instWord[15:11]` = 5'b11100 is an unconditional branch. It redirects to PC + 4 + (`instWord[10:0]` sign-extended from bit 10, times 2).
- R7: `instWord[15:11]` = 5'b11110 is the first half of the long branch. It writes the link register with PC + (`instWord[10:0]` sign-extended from bit 10, shifted left by 12). It does not redirect, and it gives `nextPc` = PC + 2.
- R8: `instWord[15:11]` = 5'b11111 is the second half. It redirects to `linkIn` + (`instWord[10:0]` zero-extended, times 2) and writes the link register with (PC + 2) | 1.
- R9: `instWord[15:11]` = 5'b11101 is the exchange second half.
  - With `instWord[0]` = 0 it behaves as in R8, except that the target has its low two bits cleared and `exitCompressed` is raised.
  - With `instWord[0]` = 1 it raises `undefInst` only.
- R10: Results appear in the cycle after the clock edge that samples `instValid` = 1. The strobes last exactly one cycle. In a cycle with no valid instruction the strobes are 0 and `nextPc` holds its value.
- R11: Any other value of `instWord[15:11]` raises no strobe and gives `nextPc` = PC + 2. At most one of `isBranch`, `undefInst` and `swiTrap` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction present this cycle |
| instWord | input | 16 | Compressed instruction |
| curPc | input | ADDR_W | Address of the instruction |
| linkIn | input | ADDR_W | Current link register value |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| flagV | input | 1 | Overflow flag |
| redirect | output | 1 | One-cycle flush and redirect pulse |
| nextPc | output | ADDR_W | Next fetch address |
| isBranch | output | 1 | Instruction was a branch format |
| linkWe | output | 1 | Link register write enable |
| linkData | output | ADDR_W | Link register write data |
| exitCompressed | output | 1 | Leave compressed mode |
| undefInst | output | 1 | Undefined encoding |
| swiTrap | output | 1 | Software interrupt request |

## Verification
Suppose the control decodes a condition or opcode group wrongly. The very next cycle would then show a redirect where PC + 2 was expected, or no redirect where a redirect was expected. An offset that is built wrongly, or sign-extended from the wrong bit, shows up at once as a `nextPc` or `linkData` value that differs from the bench's own arithmetic. The condition sweep covers every code against all sixteen flag combinations, and the offset sweeps cover both signs at the extremes of each field. A strobe that fails to clear, or a `nextPc` that drifts, shows up in the idle cycle checked after an instruction.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int INST_W = 16;

  localparam logic [4:0] OP_XCHG_HI = 5'd29;
  localparam logic [4:0] OP_COND_A  = 5'd26;
  localparam logic [4:0] OP_COND_B  = 5'd27;
  localparam logic [4:0] OP_FAR     = 5'd28;
  localparam logic [4:0] OP_LONG_LO = 5'd30;
  localparam logic [4:0] OP_LONG_HI = 5'd31;

  localparam logic [3:0] CC_UNDEF = 4'hE;
  localparam logic [3:0] CC_TRAP  = 4'hF;

  typedef enum logic [2:0] {
    TGT_SEQ,
    TGT_COND,
    TGT_FAR,
    TGT_LINK,
    TGT_LINK_ALIGN
  } tgtSel_e;

  typedef enum logic {
    LNK_HIGH,
    LNK_RET
  } lnkSel_e;

  typedef struct packed {
    logic    capture;
    logic    fire;
    tgtSel_e tgtSel;
    lnkSel_e lnkSel;
    logic    linkWe;
    logic    exitMode;
    logic    undef;
    logic    swi;
    logic    isBranch;
  } ctrlStrobe_t;
endpackage

// File: rtl/cbt_cond.sv
module cbt_cond (
  input  logic [3:0] code,
  input  logic       flagN,
  input  logic       flagZ,
  input  logic       flagC,
  input  logic       flagV,
  output logic       holds
);
  logic nvSame;
  assign nvSame = (flagN == flagV);

  always_comb begin
    unique case (code)
      4'h0: holds = flagZ;
      4'h1: holds = !flagZ;
      4'h2: holds = flagC;
      4'h3: holds = !flagC;
      4'h4: holds = flagN;
      4'h5: holds = !flagN;
      4'h6: holds = flagV;
      4'h7: holds = !flagV;
      4'h8: holds = flagC && !flagZ;
      4'h9: holds = !flagC || flagZ;
      4'hA: holds = nvSame;
      4'hB: holds = !nvSame;
      4'hC: holds = !flagZ && nvSame;
      4'hD: holds = flagZ || !nvSame;
      default: holds = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbt_ctrl.sv
module cbt_ctrl
  import cbt_pkg::*;
(
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagV,
  output ctrlStrobe_t       strb
);
  logic [4:0] opGroup;
  logic [3:0] ccode;
  logic       ccHolds;

  assign opGroup = instWord[15:11];
  assign ccode   = instWord[11:8];

  cbt_cond u_cond (
    .code  (ccode),
    .flagN (flagN),
    .flagZ (flagZ),
    .flagC (flagC),
    .flagV (flagV),
    .holds (ccHolds)
  );

  always_comb begin
    strb          = '0;
    strb.tgtSel   = TGT_SEQ;
    strb.lnkSel   = LNK_HIGH;
    strb.capture  = instValid;
    if (instValid) begin
      unique case (opGroup)
        OP_COND_A, OP_COND_B: begin
          if (ccode == CC_TRAP) begin
            strb.swi = 1'b1;
          end else if (ccode == CC_UNDEF) begin
            strb.undef = 1'b1;
          end else begin
            strb.isBranch = 1'b1;
            if (ccHolds) begin
              strb.fire   = 1'b1;
              strb.tgtSel = TGT_COND;
            end
          end
        end
        OP_FAR: begin
          strb.isBranch = 1'b1;
          strb.fire     = 1'b1;
          strb.tgtSel   = TGT_FAR;
        end
        OP_LONG_LO: begin
          strb.isBranch = 1'b1;
          strb.linkWe   = 1'b1;
          strb.lnkSel   = LNK_HIGH;
        end
        OP_LONG_HI: begin
          strb.isBranch = 1'b1;
          strb.fire     = 1'b1;
          strb.tgtSel   = TGT_LINK;
          strb.linkWe   = 1'b1;
          strb.lnkSel   = LNK_RET;
        end
        OP_XCHG_HI: begin
          if (instWord[0]) begin
            strb.undef = 1'b1;
          end else begin
            strb.isBranch = 1'b1;
            strb.fire     = 1'b1;
            strb.tgtSel   = TGT_LINK_ALIGN;
            strb.linkWe   = 1'b1;
            strb.lnkSel   = LNK_RET;
            strb.exitMode = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbt_datapath.sv
module cbt_datapath
  import cbt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic [INST_W-1:0] instWord,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] linkIn,
  output logic              redirect,
  output logic [ADDR_W-1:0] nextPc,
  output logic              isBranch,
  output logic              linkWe,
  output logic [ADDR_W-1:0] linkData,
  output logic              exitCompressed,
  output logic              undefInst,
  output logic              swiTrap
);
  localparam int SHORT_W = 8;
  localparam int LONG_W  = 11;
  localparam int HIGH_SH = 12;

  logic [ADDR_W-1:0] pcPlus2, pcPlus4;
  logic [ADDR_W-1:0] condOff, farOff, highOff, lowOff;
  logic [ADDR_W-1:0] linkSum, tgt, linkNext;

  assign pcPlus2 = curPc + ADDR_W'(2);
  assign pcPlus4 = curPc + ADDR_W'(4);

  assign condOff = {{(ADDR_W-SHORT_W-1){instWord[SHORT_W-1]}}, instWord[SHORT_W-1:0], 1'b0};
  assign farOff  = {{(ADDR_W-LONG_W-1){instWord[LONG_W-1]}}, instWord[LONG_W-1:0], 1'b0};
  assign highOff = {{(ADDR_W-LONG_W-HIGH_SH){instWord[LONG_W-1]}}, instWord[LONG_W-1:0],
                    {HIGH_SH{1'b0}}};
  assign lowOff  = {{(ADDR_W-LONG_W-1){1'b0}}, instWord[LONG_W-1:0], 1'b0};
  assign linkSum = linkIn + lowOff;

  always_comb begin
    unique case (strb.tgtSel)
      TGT_COND:       tgt = pcPlus4 + condOff;
      TGT_FAR:        tgt = pcPlus4 + farOff;
      TGT_LINK:       tgt = linkSum;
      TGT_LINK_ALIGN: tgt = linkSum & ~ADDR_W'(3);
      default:        tgt = pcPlus2;
    endcase
  end

  assign linkNext = (strb.lnkSel == LNK_HIGH) ? (curPc + highOff) : (pcPlus2 | ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect       <= 1'b0;
      nextPc         <= '0;
      isBranch       <= 1'b0;
      linkWe         <= 1'b0;
      linkData       <= '0;
      exitCompressed <= 1'b0;
      undefInst      <= 1'b0;
      swiTrap        <= 1'b0;
    end else begin
      redirect       <= strb.fire;
      isBranch       <= strb.isBranch;
      linkWe         <= strb.linkWe;
      exitCompressed <= strb.exitMode;
      undefInst      <= strb.undef;
      swiTrap        <= strb.swi;
      if (strb.capture) nextPc <= tgt;
      if (strb.linkWe) linkData <= linkNext;
    end
  end
endmodule

// File: rtl/cbt_unit.sv
module cbt_unit
  import cbt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic [15:0]       instWord,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] linkIn,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagV,
  output logic              redirect,
  output logic [ADDR_W-1:0] nextPc,
  output logic              isBranch,
  output logic              linkWe,
  output logic [ADDR_W-1:0] linkData,
  output logic              exitCompressed,
  output logic              undefInst,
  output logic              swiTrap
);
  ctrlStrobe_t strb;

  cbt_ctrl u_ctrl (
    .instValid (instValid),
    .instWord  (instWord),
    .flagN     (flagN),
    .flagZ     (flagZ),
    .flagC     (flagC),
    .flagV     (flagV),
    .strb      (strb)
  );

  cbt_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strb           (strb),
    .instWord       (instWord),
    .curPc          (curPc),
    .linkIn         (linkIn),
    .redirect       (redirect),
    .nextPc         (nextPc),
    .isBranch       (isBranch),
    .linkWe         (linkWe),
    .linkData       (linkData),
    .exitCompressed (exitCompressed),
    .undefInst      (undefInst),
    .swiTrap        (swiTrap)
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instValid,
  input logic [ADDR_W-1:0] curPc,
  input logic              redirect,
  input logic [ADDR_W-1:0] nextPc,
  input logic              isBranch,
  input logic              linkWe,
  input logic [ADDR_W-1:0] linkData,
  input logic              exitCompressed,
  input logic              undefInst,
  input logic              swiTrap
);
  logic              validQ;
  logic [ADDR_W-1:0] pcQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validQ <= 1'b0;
      pcQ    <= '0;
    end else begin
      validQ <= instValid;
      if (instValid) pcQ <= curPc;
    end
  end

  // R10
  strobe_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect || linkWe || undefInst || swiTrap || isBranch || exitCompressed) |-> validQ);

  // R10
  redirect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !instValid) |=> !redirect);

  // R10
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !validQ |-> $stable(nextPc));

  // R4
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (validQ && !redirect) |-> (nextPc == pcQ + ADDR_W'(2)));

  // R5
  trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (undefInst || swiTrap) |-> (!redirect && !linkWe && !exitCompressed));

  // R9
  exit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exitCompressed |-> (redirect && linkWe && nextPc[1:0] == 2'b00 && linkData[0]));

  // R8
  return_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (linkWe && redirect) |-> (linkData == ((pcQ + ADDR_W'(2)) | ADDR_W'(1))));

  // R11
  kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({isBranch, undefInst, swiTrap}));
endmodule

bind cbt_unit cbt_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cbt_unit_tb.sv
module cbt_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int RES_W      = 6 + 2 * ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              instValid = 1'b0;
  logic [15:0]       instWord = '0;
  logic [ADDR_W-1:0] curPc = '0;
  logic [ADDR_W-1:0] linkIn = '0;
  logic              flagN = 1'b0, flagZ = 1'b0, flagC = 1'b0, flagV = 1'b0;
  logic              redirect, isBranch, linkWe, exitCompressed, undefInst, swiTrap;
  logic [ADDR_W-1:0] nextPc, linkData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  cbt_unit #(.ADDR_W(ADDR_W)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic condTrue(logic [3:0] c, logic [3:0] nzcv);
    logic n, z, cf, v;
    {n, z, cf, v} = nzcv;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cf;
      4'd3:  return !cf;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cf & !z;
      4'd9:  return !cf | z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z & (n == v);
      4'd13: return z | (n != v);
      default: return 1'b0;
    endcase
  endfunction

  // result = {redirect, isBranch, linkWe, exit, undef, swi, nextPc, linkData-if-written}
  function automatic logic [RES_W-1:0] model(logic [15:0] i, logic [31:0] pc,
                                             logic [31:0] lnk, logic [3:0] nzcv);
    logic rd = 0, br = 0, we = 0, ex = 0, ud = 0, sw = 0;
    logic [31:0] np = pc + 2;
    logic [31:0] ld = 0;
    logic signed [31:0] s8 = 32'(signed'(i[7:0]));
    logic signed [31:0] s11 = 32'(signed'(i[10:0]));
    case (i[15:11])
      5'd26, 5'd27: begin
        if (i[11:8] == 4'hF) sw = 1;
        else if (i[11:8] == 4'hE) ud = 1;
        else begin
          br = 1;
          if (condTrue(i[11:8], nzcv)) begin rd = 1; np = pc + 4 + s8 * 2; end
        end
      end
      5'd28: begin br = 1; rd = 1; np = pc + 4 + s11 * 2; end
      5'd30: begin br = 1; we = 1; ld = pc + s11 * 4096; end
      5'd31: begin br = 1; rd = 1; we = 1; np = lnk + {20'd0, i[10:0], 1'b0}; ld = (pc + 2) | 1; end
      5'd29: begin
        if (i[0]) ud = 1;
        else begin
          br = 1; rd = 1; we = 1; ex = 1;
          np = (lnk + {20'd0, i[10:0], 1'b0}) & 32'hFFFF_FFFC;
          ld = (pc + 2) | 1;
        end
      end
      default: ;
    endcase
    return {rd, br, we, ex, ud, sw, np, ld};
  endfunction

  task automatic check(string tag, logic [RES_W-1:0] act, logic [RES_W-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s inst=%h actual=%h expected=%h", tag, instWord, act, exp);
    end
  endtask

  function automatic logic [RES_W-1:0] observed();
    return {redirect, isBranch, linkWe, exitCompressed, undefInst, swiTrap, nextPc,
            (linkWe ? linkData : 32'd0)};
  endfunction

  task automatic run(string tag, logic [15:0] i, logic [31:0] pc, logic [31:0] lnk,
                     logic [3:0] nzcv);
    @(negedge clk);
    instWord = i; curPc = pc; linkIn = lnk;
    {flagN, flagZ, flagC, flagV} = nzcv;
    instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
    check(tag, observed(), model(i, pc, lnk, nzcv));
  endtask

  task automatic idleCheck(string tag);
    logic [31:0] held = nextPc;
    @(negedge clk);
    check(tag, observed(), {6'b0, held, 32'd0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, while in reset and just after release
    check("R1", observed(), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", observed(), '0);

    // R2 R3 R4: every condition code against every flag combination
    for (int c = 0; c < 14; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [7:0] off = 8'(c * 37 + f * 11);
        string tag = condTrue(4'(c), 4'(f)) ? "R2 R3" : "R2 R4";
        run(tag, {4'hD, 4'(c), off}, 32'h1000_0000 + 32'(f * 64), 32'h0, 4'(f));
      end
    end

    // R3: full offset sweep, taken (code 0 with Z set), including wrap below zero
    for (int o = 0; o < 256; o++)
      run("R3", {4'hD, 4'h0, 8'(o)}, 32'h0000_0040, 32'h0, 4'b0100);

    // R5: trap and undefined codes, flags and offsets varied
    for (int o = 0; o < 16; o++) begin
      run("R5", {4'hD, 4'hF, 8'(o * 17)}, 32'h0000_2000, 32'h0, 4'(o));
      run("R5", {4'hD, 4'hE, 8'(o * 13)}, 32'h0000_3000, 32'h0, 4'(o));
    end

    // R6: unconditional branch offsets
    for (int o = 0; o < 2048; o += 7)
      run("R6", {5'd28, 11'(o)}, 32'h2000_0000, 32'h0, 4'h0);
    run("R6", {5'd28, 11'h7FF}, 32'h2000_0000, 32'h0, 4'h0);
    run("R6", {5'd28, 11'h400}, 32'h0000_0100, 32'h0, 4'h0);

    // R7: first half of long branch
    for (int o = 0; o < 2048; o += 13)
      run("R7", {5'd30, 11'(o)}, 32'h0100_0000 + 32'(o * 2), 32'h0, 4'h0);
    run("R7", {5'd30, 11'h7FF}, 32'h0000_0010, 32'h0, 4'h0);

    // R8: second half of long branch
    for (int o = 0; o < 2048; o += 11)
      run("R8", {5'd31, 11'(o)}, 32'h0400_0000 + 32'(o * 4), 32'h8000_0000 + 32'(o * 3),
          4'h0);
    run("R8", {5'd31, 11'h7FF}, 32'hFFFF_FFFE, 32'hFFFF_F000, 4'h0);

    // R9: exchange second half, bit 0 clear and set
    for (int o = 0; o < 2048; o += 9) begin
      run("R9", {5'd29, 11'(o & 32'h7FE)}, 32'h0300_0000, 32'h0500_0001 + 32'(o), 4'h0);
      run("R9", {5'd29, 11'(o | 1)}, 32'h0300_0000, 32'h0500_0001, 4'h0);
    end

    // R11: all other opcode groups
    for (int g = 0; g < 26; g++)
      for (int k = 0; k < 4; k++)
        run("R11", {5'(g), 11'(k * 517 + g)}, 32'h0000_8000 + 32'(g * 8), 32'h1234_5678,
            4'(k * 5));

    // R10: strobes clear and nextPc holds in cycles without a valid instruction
    run("R10", {5'd28, 11'h055}, 32'h0000_4000, 32'h0, 4'h0);
    idleCheck("R10");
    idleCheck("R10");
    run("R10", {5'd31, 11'h123}, 32'h0000_5000, 32'h0000_6000, 4'h0);
    idleCheck("R10");
    run("R10", {4'hD, 4'hF, 8'h01}, 32'h0000_7000, 32'h0, 4'h0);
    idleCheck("R10");

    // R10: back-to-back valid instructions give independent results
    @(negedge clk);
    instWord = {5'd28, 11'h002}; curPc = 32'h100; linkIn = 0; instValid = 1'b1;
    @(negedge clk);
    check("R10", observed(), model({5'd28, 11'h002}, 32'h100, 0, 4'h0));
    instWord = {5'd30, 11'h001}; curPc = 32'h200;
    @(negedge clk);
    instValid = 1'b0;
    check("R10", observed(), model({5'd30, 11'h001}, 32'h200, 0, 4'h0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule